// File: doc/BRIEF.md
# Indirect Transceiver Register Access Port

This block lets a processor reach a bank of 16-bit transceiver configuration registers through one 32-bit control word. A single bus write to the control word carries the operation, the register address and, for writes, the 16-bit payload. The port then runs the internal access over a fixed number of clock cycles while a busy flag in the same word reads as 1. When busy drops, a write has landed in the bank, and a read has left the register value in the upper half of the control word.

Software polls busy after every command and issues the next command only once busy has cleared. A command that arrives while an access is in flight is thrown away and latches a sticky error flag in a second, status word; software clears that flag by writing 1 to it. The bank comes out of reset holding a fixed default pattern. Addresses from 0x30 up to the bank size hold read-only status registers, and addresses beyond the bank read as zero.

The bus side is a plain register port: `bus_sel` picks the control word (0) or the status word (1), and every request is accepted in the cycle it is presented.

Top module: `ipa_port`

## Requirements
- R1: After reset the control word reads 0x0000_0000 (busy 0, op 0, address 0, data 0) and the status word reads 0x0000_0000.
- R2: The control word reads back as: bit 0 the operation of the last accepted command (1 write, 0 read), bit 7 busy, bits 15:8 the register address, bits 31:16 the data field; bits 6:1 read as 0.
- R3: A command accepted at a clock edge raises busy from that edge, and busy stays 1 for exactly ACCESS_LAT (default 4) clock cycles, then reads 0.
- R4: A write command (bit 0 = 1) to a writable address stores bits 31:16 into that register once busy clears; a later read returns that value.
- R5: A read command (bit 0 = 0) places the register's value in bits 31:16 of the control word when busy clears.
- R6: After reset, the register at address a holds the value {a XOR 0x5A, a} (upper byte a XOR 0x5A, lower byte a).
- R7: A control-word write while busy is 1 is dropped: the in-flight access completes with its own address and data, the dropped command touches no register, and bit 0 of the status word becomes 1.
- R8: Bit 0 of the status word is sticky; writing the status word with bit 0 = 1 clears it, writing it with bit 0 = 0 leaves it unchanged.
- R9: Registers at addresses from STATUS_BASE (0x30) to NUM_REGS-1 (0x37) are read-only: a write command to them runs its normal busy period but leaves the value unchanged.
- R10: Addresses at or above NUM_REGS (0x38) hold nothing: reads return 0 and writes change no register.
- R11: Bits 7:1 of a written command are ignored: setting them changes neither the operation nor the read-back, which shows 0 in bits 6:1.
- R12: bus_ready is 1 in every cycle in which bus_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present |
| bus_we | input | 1 | 1 for a bus write, 0 for a bus read |
| bus_sel | input | 1 | Word select: 0 control word, 1 status word |
| bus_wdata | input | 32 | Bus write data |
| bus_ready | output | 1 | Request accepted this cycle |
| bus_rdata | output | 32 | Read data of the selected word |

## Verification
The bench goes after the busy window first: it counts the cycles busy stays high, since a counter that is off by one would clear busy a cycle early or late and let software pick up stale read data. It fires a second command one cycle into a busy period; a design that did not drop it would overwrite the address or data of the access in flight or corrupt the target register, and one that dropped it silently would never raise the error flag. It writes to the read-only status range and past the end of the bank, where a missing bound check would alter a status value or alias onto a low register. It also sets the reserved and busy bits in a command, which a loose decode would echo back or mistake for part of the opcode.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

    localparam int WORD_W   = 32;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 8;

    // Field positions inside the control word
    localparam int OP_BIT   = 0;
    localparam int BUSY_BIT = 7;
    localparam int ADDR_LSB = 8;
    localparam int DATA_LSB = 16;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    typedef struct packed {
        op_e                 op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } cmd_t;

    function automatic cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.op   = op_e'(w[OP_BIT]);
        c.addr = w[ADDR_LSB +: ADDR_W];
        c.data = w[DATA_LSB +: DATA_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl(input cmd_t c, input logic busy);
        logic [WORD_W-1:0] w;
        w                      = '0;
        w[OP_BIT]              = c.op;
        w[BUSY_BIT]            = busy;
        w[ADDR_LSB +: ADDR_W]  = c.addr;
        w[DATA_LSB +: DATA_W]  = c.data;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] reg_default(input logic [ADDR_W-1:0] a);
        return {a ^ 8'h5A, a};
    endfunction

endpackage

// File: rtl/ipa_cmd_decode.sv
module ipa_cmd_decode
    import ipa_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic              bus_sel,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              busy,
    output logic              cmd_start,
    output logic              cmd_drop,
    output logic              err_clr,
    output cmd_t              cmd
);

    logic ctrl_wr;

    always_comb begin
        ctrl_wr   = bus_valid && bus_we && !bus_sel;
        cmd_start = ctrl_wr && !busy;
        cmd_drop  = ctrl_wr && busy;
        err_clr   = bus_valid && bus_we && bus_sel && bus_wdata[0];
        cmd       = unpack_cmd(bus_wdata);
    end

endmodule

// File: rtl/ipa_reg_bank.sv
module ipa_reg_bank
    import ipa_pkg::*;
#(
    parameter int NUM_REGS    = 56,
    parameter int STATUS_BASE = 48,
    parameter int ACCESS_LAT  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  cmd_t              req_cmd,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int CNT_W = $clog2(ACCESS_LAT + 1);
    localparam logic [ADDR_W:0] NREG_L = (ADDR_W + 1)'(NUM_REGS);
    localparam logic [ADDR_W:0] SBASE_L = (ADDR_W + 1)'(STATUS_BASE);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(ACCESS_LAT - 1);

    logic [DATA_W-1:0] mem [NUM_REGS];
    cmd_t              pend;
    logic              pending;
    logic [CNT_W-1:0]  cnt;
    logic              in_range;
    logic              writable;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        in_range = {1'b0, pend.addr} < NREG_L;
        writable = in_range && ({1'b0, pend.addr} < SBASE_L);
        idx      = pend.addr[IDX_W-1:0];
        done     = pending && (cnt == '0);
        rd_data  = in_range ? mem[idx] : '0;
    end

    // Fixed-latency access timer
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            cnt     <= '0;
            pend    <= '0;
        end else if (req && !pending) begin
            pending <= 1'b1;
            cnt     <= CNT_INIT;
            pend    <= req_cmd;
        end else if (pending) begin
            if (cnt == '0) begin
                pending <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Storage, loaded with the default pattern on reset
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= reg_default(ADDR_W'(i));
            end
        end else if (done && pend.op == OP_WRITE && writable) begin
            mem[idx] <= pend.data;
        end
    end

endmodule

// File: rtl/ipa_seq.sv
module ipa_seq
    import ipa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  cmd_t              cmd,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              req,
    output logic              busy,
    output cmd_t              ctl
);

    assign req = cmd_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            ctl  <= '0;
        end else if (cmd_start) begin
            busy <= 1'b1;
            ctl  <= cmd;
        end else if (busy && done) begin
            busy <= 1'b0;
            if (ctl.op == OP_READ) begin
                ctl.data <= rd_data;
            end
        end
    end

endmodule

// File: rtl/ipa_port.sv
module ipa_port
    import ipa_pkg::*;
#(
    parameter int NUM_REGS    = 56,
    parameter int STATUS_BASE = 48,
    parameter int ACCESS_LAT  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_we,
    input  logic        bus_sel,
    input  logic [31:0] bus_wdata,
    output logic        bus_ready,
    output logic [31:0] bus_rdata
);

    logic              busy;
    logic              cmd_start;
    logic              cmd_drop;
    logic              err_clr;
    logic              err_sticky;
    logic              req;
    logic              done;
    logic [DATA_W-1:0] rd_data;
    cmd_t              cmd;
    cmd_t              ctl;

    ipa_cmd_decode u_dec (
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .cmd_start (cmd_start),
        .cmd_drop  (cmd_drop),
        .err_clr   (err_clr),
        .cmd       (cmd)
    );

    ipa_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .cmd       (cmd),
        .done      (done),
        .rd_data   (rd_data),
        .req       (req),
        .busy      (busy),
        .ctl       (ctl)
    );

    ipa_reg_bank #(
        .NUM_REGS    (NUM_REGS),
        .STATUS_BASE (STATUS_BASE),
        .ACCESS_LAT  (ACCESS_LAT)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .req_cmd (cmd),
        .done    (done),
        .rd_data (rd_data)
    );

    // Sticky drop flag: a new drop wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            err_sticky <= 1'b0;
        end else if (cmd_drop) begin
            err_sticky <= 1'b1;
        end else if (err_clr) begin
            err_sticky <= 1'b0;
        end
    end

    always_comb begin
        bus_ready = bus_valid;
        bus_rdata = bus_sel ? {31'b0, err_sticky} : pack_ctrl(ctl, busy);
    end

endmodule

// File: rtl/ipa_port_checker.sv
module ipa_port_checker #(
    parameter int ACCESS_LAT = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_valid,
    input logic       bus_we,
    input logic       bus_sel,
    input logic [31:0] bus_wdata,
    input logic       busy,
    input logic       err_sticky,
    input logic [7:0] ctl_addr,
    input logic       ctl_op
);

    int run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_len <= 0;
        end else begin
            run_len <= run_len + 1;
        end
    end

    // R3: busy lasts exactly the access latency
    a_r3_busy_window: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_len == ACCESS_LAT);

    // R3: busy only rises from an accepted control-word write
    a_r3_busy_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_valid && bus_we && !bus_sel));

    // R7: a command during busy leaves the in-flight address and op alone
    a_r7_drop_keeps_cmd: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_valid && bus_we && !bus_sel) |=> ($stable(ctl_addr) && $stable(ctl_op)));

    // R7: a dropped command raises the error flag
    a_r7_drop_flags: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_valid && bus_we && !bus_sel) |=> err_sticky);

    // R8: writing 1 to the status bit clears the flag
    a_r8_err_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && bus_sel && bus_wdata[0]) |=> !err_sticky);

endmodule

bind ipa_port ipa_port_checker #(.ACCESS_LAT(ACCESS_LAT)) u_ipa_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .err_sticky (err_sticky),
    .ctl_addr   (ctl.addr),
    .ctl_op     (ctl.op)
);

// File: tb/ipa_port_bench.sv
`timescale 1ns/1ps
module ipa_port_bench;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid;
    logic        bus_we;
    logic        bus_sel;
    logic [31:0] bus_wdata;
    logic        bus_ready;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    ipa_port #(.NUM_REGS(56), .STATUS_BASE(48), .ACCESS_LAT(LAT)) u_ipa_port (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] dflt(input logic [7:0] a);
        return {a ^ 8'h5A, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sel, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic sel, output logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_sel = sel;
        #1;
        data = bus_rdata;
        chk("R12 ready", {31'b0, bus_ready}, 32'h1);
        bus_valid = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] w;
        for (int i = 0; i < 50; i++) begin
            bus_rd(1'b0, w);
            if (!w[7]) return;
        end
        chk("R3 busy never cleared", w, {w[31:8], 1'b0, w[6:0]});
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [15:0] d);
        bus_wr(1'b0, {d, a, 8'h01});
        wait_idle();
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [15:0] d);
        logic [31:0] w;
        bus_wr(1'b0, {16'h0000, a, 8'h00});
        wait_idle();
        bus_rd(1'b0, w);
        d = w[31:16];
    endtask

    task automatic t_reset();
        logic [31:0] w;
        bus_rd(1'b0, w);
        chk("R1 control word", w, 32'h0);
        bus_rd(1'b1, w);
        chk("R1 status word", w, 32'h0);
    endtask

    task automatic t_defaults();
        logic [15:0] d;
        reg_rd(8'h00, d); chk("R6 default 0x00", {16'h0, d}, {16'h0, dflt(8'h00)});
        reg_rd(8'h09, d); chk("R5 R6 default 0x09", {16'h0, d}, {16'h0, dflt(8'h09)});
        reg_rd(8'h2F, d); chk("R6 default 0x2F", {16'h0, d}, {16'h0, dflt(8'h2F)});
        reg_rd(8'h30, d); chk("R6 default 0x30", {16'h0, d}, {16'h0, dflt(8'h30)});
    endtask

    task automatic t_busy_len();
        logic [31:0] w;
        int high = 0;
        bus_wr(1'b0, {16'h0000, 8'h05, 8'h00});
        bus_rd(1'b0, w);
        chk("R2 fields while busy", w, {16'h0000, 8'h05, 8'h80});
        high = w[7] ? 1 : 0;
        for (int i = 0; i < LAT + 3; i++) begin
            bus_rd(1'b0, w);
            if (!w[7]) break;
            high++;
        end
        // the bus_wr task already consumed one busy cycle before the first sample
        chk("R3 busy cycles", 32'(high + 1), 32'(LAT));
        chk("R5 read data 0x05", w, {dflt(8'h05), 8'h05, 8'h00});
    endtask

    task automatic t_write_read();
        logic [15:0] d;
        logic [31:0] w;
        reg_wr(8'h0B, 16'hBEEF);
        reg_rd(8'h0B, d); chk("R4 write 0x0B", {16'h0, d}, 32'h0000_BEEF);
        reg_wr(8'h2F, 16'h1234);
        reg_rd(8'h2F, d); chk("R4 write 0x2F", {16'h0, d}, 32'h0000_1234);
        reg_rd(8'h0A, d); chk("R4 neighbour intact", {16'h0, d}, {16'h0, dflt(8'h0A)});
        reg_wr(8'h12, 16'hA5C3);
        bus_rd(1'b0, w);
        chk("R2 layout after write", w, 32'hA5C3_1201);
    endtask

    task automatic t_reserved();
        logic [31:0] w;
        logic [15:0] d;
        bus_wr(1'b0, {16'h5555, 8'h07, 8'hFF});
        wait_idle();
        bus_rd(1'b0, w);
        chk("R11 reserved ignored", w, {16'h5555, 8'h07, 8'h01});
        reg_rd(8'h07, d); chk("R11 still a write", {16'h0, d}, 32'h0000_5555);
        bus_wr(1'b0, {16'h0000, 8'h08, 8'hFE});
        wait_idle();
        bus_rd(1'b0, w);
        chk("R11 read with reserved set", w, {dflt(8'h08), 8'h08, 8'h00});
    endtask

    task automatic t_drop();
        logic [31:0] w;
        logic [15:0] d;
        bus_wr(1'b0, {16'h0000, 8'h03, 8'h00});
        bus_wr(1'b0, {16'hDEAD, 8'h04, 8'h01});
        wait_idle();
        bus_rd(1'b0, w);
        chk("R7 in-flight read kept", w, {dflt(8'h03), 8'h03, 8'h00});
        bus_rd(1'b1, w);
        chk("R7 error flag set", w, 32'h1);
        reg_rd(8'h04, d);
        chk("R7 dropped write not applied", {16'h0, d}, {16'h0, dflt(8'h04)});
    endtask

    task automatic t_err_clear();
        logic [31:0] w;
        bus_wr(1'b1, 32'hFFFF_FFFE);
        bus_rd(1'b1, w);
        chk("R8 write 0 keeps flag", w, 32'h1);
        bus_wr(1'b1, 32'h0000_0001);
        bus_rd(1'b1, w);
        chk("R8 write 1 clears flag", w, 32'h0);
    endtask

    task automatic t_status_ro();
        logic [15:0] d;
        reg_wr(8'h31, 16'hFFFF);
        reg_rd(8'h31, d); chk("R9 status 0x31 read-only", {16'h0, d}, {16'h0, dflt(8'h31)});
        reg_wr(8'h37, 16'h0000);
        reg_rd(8'h37, d); chk("R9 status 0x37 read-only", {16'h0, d}, {16'h0, dflt(8'h37)});
    endtask

    task automatic t_oob();
        logic [15:0] d;
        reg_rd(8'h40, d); chk("R10 read past bank", {16'h0, d}, 32'h0);
        reg_wr(8'h38, 16'h7777);
        reg_rd(8'h38, d); chk("R10 write past bank", {16'h0, d}, 32'h0);
        reg_rd(8'h00, d); chk("R10 no alias onto 0x00", {16'h0, d}, {16'h0, dflt(8'h00)});
    endtask

    initial begin
        rst = 1'b1; bus_valid = 1'b0; bus_we = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_defaults();
        t_busy_len();
        t_write_read();
        t_reserved();
        t_drop();
        t_err_clear();
        t_status_ro();
        t_oob();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule